// File: doc/BRIEF.md
# Sound Coprocessor I/O Register Bank

This block is the register bank at the top of a sound coprocessor's address page. The coprocessor reaches it with a byte address and separate read and write strobes. It holds four mailbox ports shared with a host CPU, and each port has one latch for each direction. It also holds an indirect window into an external DSP register file, two scratch bytes, and a control byte. The control byte drives the boot-ROM overlay enable, starts the three timers, and clears host-written mailbox latches in pairs.

Timer counting lives in a separate unit. This block only forwards the timer enables, the 8-bit targets, a start pulse when an enable turns on, and a read-clear strobe when the coprocessor reads a tick count. Reads are combinational from the current address. Writes take effect at the next rising clock edge.

An address decoder sorts each address into one register class. The classes are `RG_NONE` (undecoded), `RG_CTRL` (0xF1), `RG_DADDR` (0xF2), `RG_DDATA` (0xF3), `RG_PORT` (0xF4–0xF7), `RG_SCR0` (0xF8), `RG_SCR1` (0xF9), `RG_TGT` (0xFA–0xFC) and `RG_TCNT` (0xFD–0xFF). Each bus cycle moves from the idle class to the decoded class and back, with no state kept between cycles. The read multiplexer and every write-enable branch on this class.

Top module: `snd_io_regs`

## Requirements
- R1: After reset every mailbox latch, both scratch bytes, the DSP address and all timer targets are 0x00. `boot_en` is 1, and `tmr_en` and `tmr_start` are 0.
- R2: A coprocessor write to 0xF4–0xF7 loads the host-readable latch chosen by address bits 1:0. `host_rdata` shows the latch selected by `host_sel` from the next cycle on.
- R3: A coprocessor read of 0xF4–0xF7 returns the latch the host last wrote for that port, never the coprocessor's own write.
- R4: A write to 0xF1 sets `boot_en` from bit 7 and `tmr_en[2:0]` from bits 2..0. For each enable that goes from 0 to 1, `tmr_start` pulses for exactly one cycle, in the same cycle that the enable first reads 1.
- R5: A write to 0xF1 with bit 5 set clears host-written ports 2 and 3 to 0x00, and with bit 4 set clears ports 0 and 1. When a host write to a port lands in the same cycle as its clear, the clear wins.
- R6: A write to 0xF2 stores an 8-bit DSP address, and a read of 0xF2 returns it unchanged.
- R7: `dsp_addr` is the stored address with bit 7 removed. A read of 0xF3 returns `dsp_rdata`.
- R8: A write to 0xF3 raises `dsp_we` with `dsp_wdata` equal to the write data, but only when bit 7 of the stored address is 0. Otherwise `dsp_we` stays 0.
- R9: 0xF8 and 0xF9 are independent 8-bit read/write scratch bytes.
- R10: Reads of 0xF1, 0xFA–0xFC and any address below 0xF1 return 0x00, and so does any cycle with `cp_rd` low.
- R11: Writes to 0xFA, 0xFB and 0xFC load the targets of timers 0, 1 and 2. Timer t's target sits in `tmr_target[8t+7:8t]`.
- R12: A read of 0xFD, 0xFE or 0xFF returns the 4-bit tick count of timer 0, 1 or 2 (`tmr_ticks[4t+3:4t]`) zero-extended. In that same cycle it raises only the matching `tmr_rdclr` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_addr | input | 8 | Coprocessor byte address within the page |
| cp_rd | input | 1 | Coprocessor read strobe |
| cp_wr | input | 1 | Coprocessor write strobe |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rdata | output | 8 | Coprocessor read data (combinational) |
| host_sel | input | 2 | Host port select |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Coprocessor-written latch for the selected port |
| dsp_addr | output | 7 | DSP register address |
| dsp_rdata | input | 8 | DSP register read data |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_we | output | 1 | DSP register write enable |
| boot_en | output | 1 | Boot-ROM overlay enable |
| tmr_en | output | 3 | Timer enables |
| tmr_start | output | 3 | One-cycle start pulse for each timer |
| tmr_target | output | 24 | Packed timer targets |
| tmr_ticks | input | 12 | Packed 4-bit tick counts from the timer unit |
| tmr_rdclr | output | 3 | Tick-count read-clear strobes |

## Verification
A corrupt mailbox latch shows up on the very next read of that port: from the coprocessor side for host-written latches, and at once on `host_rdata` for the other direction. A wrong stored DSP address shows on `dsp_addr` in the same cycle, and on whether a window write raises `dsp_we`. Control-byte faults show on `boot_en`, `tmr_en` and `tmr_start` one cycle after the write. The bench compares every output against a behavioural model on each clock, so any such divergence is caught within a cycle of the operation that exposes it.

// File: rtl/snd_io_pkg.sv
package snd_io_pkg;
    localparam int DW = 8;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_DADDR,
        RG_DDATA,
        RG_PORT,
        RG_SCR0,
        RG_SCR1,
        RG_TGT,
        RG_TCNT
    } reg_kind_e;
endpackage

// File: rtl/snd_io_decode.sv
module snd_io_decode
    import snd_io_pkg::*;
(
    input  logic [7:0] addr,
    output reg_kind_e  kind,
    output logic [1:0] idx
);
    always_comb begin
        idx = addr[1:0];
        unique case (addr)
            8'hF1: kind = RG_CTRL;
            8'hF2: kind = RG_DADDR;
            8'hF3: kind = RG_DDATA;
            8'hF4, 8'hF5, 8'hF6, 8'hF7: kind = RG_PORT;
            8'hF8: kind = RG_SCR0;
            8'hF9: kind = RG_SCR1;
            8'hFA: begin kind = RG_TGT;  idx = 2'd0; end
            8'hFB: begin kind = RG_TGT;  idx = 2'd1; end
            8'hFC: begin kind = RG_TGT;  idx = 2'd2; end
            8'hFD: begin kind = RG_TCNT; idx = 2'd0; end
            8'hFE: begin kind = RG_TCNT; idx = 2'd1; end
            8'hFF: begin kind = RG_TCNT; idx = 2'd2; end
            default: kind = RG_NONE;
        endcase
    end
endmodule

// File: rtl/snd_mailbox.sv
module snd_mailbox #(
    parameter int NPORT = 4,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cp_we,
    input  logic [$clog2(NPORT)-1:0] cp_sel,
    input  logic [DW-1:0]            cp_wdata,
    output logic [DW-1:0]            cp_rdata,
    input  logic                     host_we,
    input  logic [$clog2(NPORT)-1:0] host_sel,
    input  logic [DW-1:0]            host_wdata,
    output logic [DW-1:0]            host_rdata,
    input  logic [NPORT/2-1:0]       pair_clr
);
    localparam int SW = $clog2(NPORT);

    logic [DW-1:0] c2h_q [NPORT];
    logic [DW-1:0] h2c_q [NPORT];

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n)
                c2h_q[g] <= '0;
            else if (cp_we && cp_sel == SW'(g))
                c2h_q[g] <= cp_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                h2c_q[g] <= '0;
            else if (pair_clr[g/2])
                h2c_q[g] <= '0;
            else if (host_we && host_sel == SW'(g))
                h2c_q[g] <= host_wdata;
        end
    end

    assign cp_rdata   = h2c_q[cp_sel];
    assign host_rdata = c2h_q[host_sel];

    p_clear_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_clr[0] |=> (h2c_q[0] == '0 && h2c_q[1] == '0));
endmodule

// File: rtl/snd_dsp_window.sv
module snd_dsp_window #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          data_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] addr_rdata,
    output logic [DW-2:0] dsp_addr,
    output logic [DW-1:0] dsp_wdata,
    output logic          dsp_we
);
    localparam int LOCK_BIT = DW - 1;

    logic [DW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (addr_we)
            addr_q <= wdata;
    end

    assign addr_rdata = addr_q;
    assign dsp_addr   = addr_q[LOCK_BIT-1:0];
    assign dsp_wdata  = wdata;
    assign dsp_we     = data_we && !addr_q[LOCK_BIT];

    p_addr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> addr_rdata == $past(wdata));
endmodule

// File: rtl/snd_ctrl_regs.sv
module snd_ctrl_regs #(
    parameter int DW   = 8,
    parameter int NTMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [1:0]         scr_we,
    input  logic               tgt_we,
    input  logic [1:0]         tgt_idx,
    input  logic [DW-1:0]      wdata,
    output logic               boot_en,
    output logic [NTMR-1:0]    tmr_en,
    output logic [NTMR-1:0]    tmr_start,
    output logic [NTMR*DW-1:0] tmr_target,
    output logic [DW-1:0]      scr0,
    output logic [DW-1:0]      scr1,
    output logic [1:0]         pair_clr
);
    localparam int BOOT_BIT   = 7;
    localparam int CLR_HI_BIT = 5;
    localparam int CLR_LO_BIT = 4;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_en   <= 1'b1;
            tmr_en    <= '0;
            tmr_start <= '0;
        end else if (ctrl_we) begin
            boot_en   <= wdata[BOOT_BIT];
            tmr_en    <= wdata[NTMR-1:0];
            tmr_start <= wdata[NTMR-1:0] & ~tmr_en;
        end else begin
            tmr_start <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr0 <= '0;
            scr1 <= '0;
        end else begin
            if (scr_we[0]) scr0 <= wdata;
            if (scr_we[1]) scr1 <= wdata;
        end
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (!rst_n)
                tmr_target[t*DW +: DW] <= '0;
            else if (tgt_we && tgt_idx == 2'(t))
                tmr_target[t*DW +: DW] <= wdata;
        end

        p_start_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_start[t] |-> (tmr_en[t] && !$past(tmr_en[t])));
    end

    assign pair_clr = ctrl_we ? {wdata[CLR_HI_BIT], wdata[CLR_LO_BIT]} : 2'b00;

    p_boot_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> boot_en == $past(wdata[BOOT_BIT]));

    p_scr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_we[0] |=> $stable(scr0));
endmodule

// File: rtl/snd_io_regs.sv
module snd_io_regs
    import snd_io_pkg::*;
#(
    parameter int NTMR  = 3,
    parameter int TW    = 4,
    parameter int NPORT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cp_addr,
    input  logic               cp_rd,
    input  logic               cp_wr,
    input  logic [DW-1:0]      cp_wdata,
    output logic [DW-1:0]      cp_rdata,
    input  logic [1:0]         host_sel,
    input  logic               host_wr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic [DW-2:0]      dsp_addr,
    input  logic [DW-1:0]      dsp_rdata,
    output logic [DW-1:0]      dsp_wdata,
    output logic               dsp_we,
    output logic               boot_en,
    output logic [NTMR-1:0]    tmr_en,
    output logic [NTMR-1:0]    tmr_start,
    output logic [NTMR*DW-1:0] tmr_target,
    input  logic [NTMR*TW-1:0] tmr_ticks,
    output logic [NTMR-1:0]    tmr_rdclr
);
    reg_kind_e     kind;
    logic [1:0]    idx;
    logic [DW-1:0] mb_rdata, win_addr, scr0, scr1, tick_ext;
    logic [1:0]    pair_clr;

    snd_io_decode u_dec (
        .addr (cp_addr),
        .kind (kind),
        .idx  (idx)
    );

    snd_mailbox #(.NPORT(NPORT), .DW(DW)) u_mb (
        .clk        (clk),
        .rst_n      (rst_n),
        .cp_we      (cp_wr && kind == RG_PORT),
        .cp_sel     (idx),
        .cp_wdata   (cp_wdata),
        .cp_rdata   (mb_rdata),
        .host_we    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pair_clr   (pair_clr)
    );

    snd_dsp_window #(.DW(DW)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (cp_wr && kind == RG_DADDR),
        .data_we    (cp_wr && kind == RG_DDATA),
        .wdata      (cp_wdata),
        .addr_rdata (win_addr),
        .dsp_addr   (dsp_addr),
        .dsp_wdata  (dsp_wdata),
        .dsp_we     (dsp_we)
    );

    snd_ctrl_regs #(.DW(DW), .NTMR(NTMR)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (cp_wr && kind == RG_CTRL),
        .scr_we     ({cp_wr && kind == RG_SCR1, cp_wr && kind == RG_SCR0}),
        .tgt_we     (cp_wr && kind == RG_TGT),
        .tgt_idx    (idx),
        .wdata      (cp_wdata),
        .boot_en    (boot_en),
        .tmr_en     (tmr_en),
        .tmr_start  (tmr_start),
        .tmr_target (tmr_target),
        .scr0       (scr0),
        .scr1       (scr1),
        .pair_clr   (pair_clr)
    );

    always_comb begin
        tick_ext = '0;
        for (int t = 0; t < NTMR; t++)
            if (idx == 2'(t))
                tick_ext = {{(DW-TW){1'b0}}, tmr_ticks[t*TW +: TW]};
    end

    always_comb begin
        cp_rdata = '0;
        if (cp_rd) begin
            unique case (kind)
                RG_DADDR: cp_rdata = win_addr;
                RG_DDATA: cp_rdata = dsp_rdata;
                RG_PORT:  cp_rdata = mb_rdata;
                RG_SCR0:  cp_rdata = scr0;
                RG_SCR1:  cp_rdata = scr1;
                RG_TCNT:  cp_rdata = tick_ext;
                default:  cp_rdata = '0;
            endcase
        end
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_rdclr
        assign tmr_rdclr[t] = cp_rd && kind == RG_TCNT && idx == 2'(t);
    end

    p_rdclr_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_rdclr));
endmodule

// File: tb/tb_snd_io_regs.sv
`timescale 1ns/1ps
module tb_snd_io_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cp_addr = '0, cp_wdata = '0, host_wdata = '0, dsp_rdata = '0;
    logic        cp_rd = 1'b0, cp_wr = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [11:0] tmr_ticks = '0;
    logic [7:0]  cp_rdata, host_rdata, dsp_wdata;
    logic [6:0]  dsp_addr;
    logic        dsp_we, boot_en;
    logic [2:0]  tmr_en, tmr_start, tmr_rdclr;
    logic [23:0] tmr_target;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    snd_io_regs dut (
        .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_rd(cp_rd), .cp_wr(cp_wr),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dsp_addr(dsp_addr),
        .dsp_rdata(dsp_rdata), .dsp_wdata(dsp_wdata), .dsp_we(dsp_we), .boot_en(boot_en),
        .tmr_en(tmr_en), .tmr_start(tmr_start), .tmr_target(tmr_target),
        .tmr_ticks(tmr_ticks), .tmr_rdclr(tmr_rdclr)
    );

    // behavioural model state
    logic [7:0] m_h2c [4];
    logic [7:0] m_c2h [4];
    logic [7:0] m_tgt [3];
    logic [7:0] m_daddr, m_scr0, m_scr1;
    logic       m_boot;
    logic [2:0] m_en, m_start;

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_h2c[i] = 0; m_c2h[i] = 0; end
        for (int i = 0; i < 3; i++) m_tgt[i] = 0;
        m_daddr = 0; m_scr0 = 0; m_scr1 = 0; m_boot = 1; m_en = 0; m_start = 0;
    endtask

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (!cp_rd) return 8'h00;
        case (a)
            8'hF2: return m_daddr;
            8'hF3: return dsp_rdata;
            8'hF4, 8'hF5, 8'hF6, 8'hF7: return m_h2c[a[1:0]];
            8'hF8: return m_scr0;
            8'hF9: return m_scr1;
            8'hFD: return {4'h0, tmr_ticks[3:0]};
            8'hFE: return {4'h0, tmr_ticks[7:4]};
            8'hFF: return {4'h0, tmr_ticks[11:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'hF2: return "R6";
            8'hF3: return "R7";
            8'hF4, 8'hF5, 8'hF6, 8'hF7: return "R3";
            8'hF8, 8'hF9: return "R9";
            8'hFD, 8'hFE, 8'hFF: return "R12";
            default: return "R10";
        endcase
    endfunction

    // one bus cycle: drive, compare every output, clock, update model
    task automatic step(input logic [7:0] a, input logic rd, input logic wr, input logic [7:0] d,
                        input logic hw, input logic [1:0] hs, input logic [7:0] hd,
                        input string rtag);
        logic       we_exp;
        logic [2:0] rc_exp;
        logic [2:0] new_en;
        cp_addr = a; cp_rd = rd; cp_wr = wr; cp_wdata = d;
        host_wr = hw; host_sel = hs; host_wdata = hd;
        dsp_rdata = 8'($urandom); tmr_ticks = 12'($urandom);
        #1;
        chk(rtag == "" ? tag_of(a) : rtag, "cp_rdata", cp_rdata, exp_read(a));
        chk("R2", "host_rdata", host_rdata, m_c2h[hs]);
        chk("R7", "dsp_addr", dsp_addr, m_daddr[6:0]);
        we_exp = wr && a == 8'hF3 && !m_daddr[7];
        chk("R8", "dsp_we", dsp_we, we_exp);
        if (we_exp) chk("R8", "dsp_wdata", dsp_wdata, d);
        chk("R4", "boot_en", boot_en, m_boot);
        chk("R4", "tmr_en", tmr_en, m_en);
        chk("R4", "tmr_start", tmr_start, m_start);
        chk("R11", "tmr_target", tmr_target, {m_tgt[2], m_tgt[1], m_tgt[0]});
        rc_exp = 3'b000;
        if (rd && a == 8'hFD) rc_exp = 3'b001;
        if (rd && a == 8'hFE) rc_exp = 3'b010;
        if (rd && a == 8'hFF) rc_exp = 3'b100;
        chk("R12", "tmr_rdclr", tmr_rdclr, rc_exp);
        @(posedge clk);
        m_start = 0;
        if (hw) m_h2c[hs] = hd;
        if (wr) begin
            case (a)
                8'hF1: begin
                    new_en = d[2:0];
                    m_start = new_en & ~m_en;
                    m_en = new_en;
                    m_boot = d[7];
                    if (d[5]) begin m_h2c[2] = 0; m_h2c[3] = 0; end
                    if (d[4]) begin m_h2c[0] = 0; m_h2c[1] = 0; end
                end
                8'hF2: m_daddr = d;
                8'hF4, 8'hF5, 8'hF6, 8'hF7: m_c2h[a[1:0]] = d;
                8'hF8: m_scr0 = d;
                8'hF9: m_scr1 = d;
                8'hFA: m_tgt[0] = d;
                8'hFB: m_tgt[1] = d;
                8'hFC: m_tgt[2] = d;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values across all outputs
        step(8'hF4, 1, 0, 0, 0, 0, 0, "R1");
        step(8'hF2, 1, 0, 0, 0, 0, 0, "R1");
        // R3: host writes, coprocessor reads its own direction
        for (int p = 0; p < 4; p++) step(8'h00, 0, 0, 0, 1, 2'(p), 8'(8'h11 * (p + 1)), "");
        for (int p = 0; p < 4; p++) step(8'(8'hF4 + p), 1, 0, 0, 0, 0, 0, "R3");
        // R2: coprocessor writes do not disturb host-written side
        for (int p = 0; p < 4; p++) step(8'(8'hF4 + p), 0, 1, 8'(8'hA0 + p), 0, 2'(p), 0, "");
        for (int p = 0; p < 4; p++) step(8'(8'hF4 + p), 1, 0, 0, 0, 2'(p), 0, "R3");
        // R5: clear upper pair while host writes port 2 in the same cycle
        step(8'hF1, 0, 1, 8'h21, 1, 2'd2, 8'h99, "");
        step(8'hF6, 1, 0, 0, 0, 0, 0, "R5");
        step(8'hF7, 1, 0, 0, 0, 0, 0, "R5");
        step(8'hF4, 1, 0, 0, 0, 0, 0, "R5");
        step(8'hF1, 0, 1, 8'h13, 1, 2'd0, 8'h55, "");
        step(8'hF4, 1, 0, 0, 0, 0, 0, "R5");
        // R4 / R10: control read returns zero, boot disable
        step(8'hF1, 0, 1, 8'h07, 0, 0, 0, "");
        step(8'hF1, 1, 0, 0, 0, 0, 0, "R10");
        // R6/R7/R8: locked and unlocked window writes
        step(8'hF2, 0, 1, 8'h85, 0, 0, 0, "");
        step(8'hF3, 0, 1, 8'h3C, 0, 0, 0, "");
        step(8'hF2, 1, 0, 0, 0, 0, 0, "R6");
        step(8'hF2, 0, 1, 8'h05, 0, 0, 0, "");
        step(8'hF3, 0, 1, 8'h3C, 0, 0, 0, "");
        step(8'hF3, 1, 0, 0, 0, 0, 0, "R7");
        // R9, R11, R12
        step(8'hF8, 0, 1, 8'h5A, 0, 0, 0, "");
        step(8'hF9, 0, 1, 8'hC3, 0, 0, 0, "");
        step(8'hF8, 1, 0, 0, 0, 0, 0, "R9");
        step(8'hF9, 1, 0, 0, 0, 0, 0, "R9");
        for (int t = 0; t < 3; t++) step(8'(8'hFA + t), 0, 1, 8'(8'h10 + t), 0, 0, 0, "");
        for (int t = 0; t < 3; t++) step(8'(8'hFA + t), 1, 0, 0, 0, 0, 0, "R10");
        for (int t = 0; t < 3; t++) step(8'(8'hFD + t), 1, 0, 0, 0, 0, 0, "R12");
        // mixed traffic over the whole page
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] a;
            logic       w;
            a = ($urandom % 8 == 0) ? 8'($urandom) : 8'(8'hF0 + $urandom % 16);
            w = 1'($urandom);
            step(a, !w, w, 8'($urandom), 1'($urandom), 2'($urandom), 8'($urandom), "");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule